// File: doc/BRIEF.md
# Region-Selectable CPU/PPU Clock Phaser

This block turns one master clock into the timing strobes that a processor core and a picture unit need. A two-bit region code picks how many master clocks make one processor cycle and one picture dot. Each processor cycle is cut into two halves. The block marks the end of the first half with a start-of-cycle strobe and the end of the whole cycle with an end-of-cycle strobe. The cut point moves by one master clock depending on whether the cycle reads or writes. In one region the two nominal halves are unequal.

A master count is preloaded at reset and then advances once per clock. The picture-dot enable is taken from this count after a loadable phase offset is subtracted. After reset the block runs eight dummy read cycles before the core may start real work. It also keeps a count of processor cycles, whose lowest bit gives the even/odd parity that a DMA engine needs.

The block also produces the stack pointer and register-clear values that the core loads for a cold or a warm reset. The region and both offsets are captured only while reset is held, so a cycle is never stretched or cut short partway through.

Top module: `region_clk_phaser`

## Requirements
- R1: The region code sets the cycle length / dot spacing in master clocks: 00 gives 12/4, 01 gives 16/5, 10 gives 15/5, and 11 behaves like 00. The nominal first/second halves are 6/6, 8/8 and 7/8 for codes 00, 01 and 10.
- R2: Clock indices within a cycle count from 0 at the first clock after the previous end strobe. In a read cycle the first half lasts h1-1 clocks, so `cyc_start` is high at index h1-2. `cyc_end` is high at index div-1, once per cycle.
- R3: In a write cycle the first half lasts h1+1 clocks, so `cyc_start` is high at index h1. `cyc_wr` is high for the whole cycle.
- R4: `next_wr` is sampled on the clock where `cyc_end` is high and sets the type of the next cycle only. A request that is dropped before the next end strobe does not carry over.
- R5: During reset `master_cnt` loads div + min(cpu_off, div-1). After reset it rises by one every clock.
- R6: `ppu_dot` is high exactly in clocks where (master_cnt - min(ppu_off, pdiv-1)) mod pdiv equals 0.
- R7: After reset the first 8 cycles are reads with `boot_busy` high, whatever `next_wr` is. `boot_busy` falls with the first clock of cycle 8.
- R8: `cyc_cnt` is 0 after reset and rises by one in the clock after each `cyc_end`. Bit 0 of it is the get/put parity.
- R9: On a cold reset (`warm_rst`=0) `sp_init` is 0xFD and `axy_clr` is 1. On a warm reset `sp_init` is `sp_now`-3 modulo 256, sampled during reset, and `axy_clr` is 0. Both hold after reset is released.
- R10: Changes to `region_sel`, `cpu_off` or `ppu_off` while reset is low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high; samples the configuration |
| region_sel | input | 2 | Region code (see R1) |
| cpu_off | input | COFF_W | Processor phase offset added to the master preload |
| ppu_off | input | POFF_W | Picture phase offset subtracted from the master count |
| warm_rst | input | 1 | 1 = warm reset, 0 = cold reset (sampled in reset) |
| sp_now | input | 8 | Current stack pointer, used for a warm reset |
| next_wr | input | 1 | Type of the next cycle: 1 = write |
| cyc_start | output | 1 | End of the first half of the current cycle |
| cyc_end | output | 1 | Last master clock of the current cycle |
| cyc_wr | output | 1 | Current cycle is a write |
| boot_busy | output | 1 | Power-up dummy cycles still running |
| cyc_cnt | output | CYC_W | Processor cycle count |
| master_cnt | output | MASTER_W | Master clock count |
| ppu_dot | output | 1 | Picture dot enable |
| sp_init | output | 8 | Stack pointer value to load after reset |
| axy_clr | output | 1 | Clear the accumulator and index registers |

## Verification
The hardest case to reach from the ports is a write cycle right after the dummy run. The write request is ignored for eight cycles, so a bench that raises it early cannot show whether the boot gate or the sampling point is wrong. The stimulus therefore holds `next_wr` high through the whole boot in some table rows, where every dummy cycle must still show the read cut point. A directed test then raises the request for the single clock of one end strobe and checks that exactly one write cycle follows. Each table row also changes the region code and both offsets partway through the run. The expected timing is unchanged, which shows that a mid-run region change cannot bend a cycle.

// File: rtl/region_clk_phaser_pkg.sv
package region_clk_phaser_pkg;

   localparam int unsigned MAX_DIV = 16;
   localparam int unsigned DIV_W   = $clog2(MAX_DIV + 1);
   localparam int unsigned PDIV_W  = 3;

   typedef struct packed {
      logic [DIV_W-1:0]  div;
      logic [DIV_W-1:0]  h1;
      logic [PDIV_W-1:0] pdiv;
   } phase_cfg_t;

   function automatic phase_cfg_t region_cfg(input logic [1:0] sel);
      phase_cfg_t c;
      case (sel)
         2'b01:   begin c.div = DIV_W'(16); c.h1 = DIV_W'(8); c.pdiv = PDIV_W'(5); end
         2'b10:   begin c.div = DIV_W'(15); c.h1 = DIV_W'(7); c.pdiv = PDIV_W'(5); end
         default: begin c.div = DIV_W'(12); c.h1 = DIV_W'(6); c.pdiv = PDIV_W'(4); end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/region_clk_phaser_cfg.sv
module region_clk_phaser_cfg
   import region_clk_phaser_pkg::*;
#(
   parameter int unsigned COFF_W   = 5,
   parameter int unsigned POFF_W   = 3,
   parameter int unsigned MASTER_W = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [1:0]          region_sel,
   input  logic [COFF_W-1:0]   cpu_off,
   input  logic [POFF_W-1:0]   ppu_off,
   input  logic                warm_rst,
   input  logic [7:0]          sp_now,
   output phase_cfg_t          cfg_q,
   output logic [MASTER_W-1:0] base_live,
   output logic [PDIV_W-1:0]   pph_live,
   output logic [7:0]          sp_init,
   output logic                axy_clr
);

   generate
      if (COFF_W > 8 || POFF_W > 8) begin : g_off_w_bad
         $error("offset widths must not exceed 8 bits");
      end
      if (MASTER_W < 8) begin : g_master_w_bad
         $error("master count needs at least 8 bits");
      end
   endgenerate

   phase_cfg_t live;
   logic [7:0] div8, pdiv8, coff8, poff8, cmax8, pmax8, ceff8, peff8, base8, diff8;

   always_comb begin
      live      = region_cfg(region_sel);
      div8      = 8'(live.div);
      pdiv8     = 8'(live.pdiv);
      coff8     = 8'(cpu_off);
      poff8     = 8'(ppu_off);
      cmax8     = div8 - 8'd1;
      pmax8     = pdiv8 - 8'd1;
      ceff8     = (coff8 > cmax8) ? cmax8 : coff8;
      peff8     = (poff8 > pmax8) ? pmax8 : poff8;
      base8     = div8 + ceff8;
      diff8     = base8 - peff8;
      base_live = MASTER_W'(base8);
      pph_live  = PDIV_W'(diff8 % pdiv8);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q   <= live;
         sp_init <= warm_rst ? (sp_now - 8'd3) : 8'hFD;
         axy_clr <= ~warm_rst;
      end
   end

endmodule

// File: rtl/region_clk_phaser_cpu.sv
module region_clk_phaser_cpu
   import region_clk_phaser_pkg::*;
#(
   parameter int unsigned CYC_W       = 16,
   parameter int unsigned BOOT_CYCLES = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] div,
   input  logic [DIV_W-1:0] h1,
   input  logic             next_wr,
   output logic             cyc_start,
   output logic             cyc_end,
   output logic             cyc_wr,
   output logic             boot_busy,
   output logic [CYC_W-1:0] cyc_cnt
);

   localparam int unsigned BOOT_W = $clog2(BOOT_CYCLES + 1);

   generate
      if (BOOT_CYCLES < 1) begin : g_boot_bad
         $error("at least one dummy cycle is required");
      end
      if (CYC_W < 1) begin : g_cyc_bad
         $error("cycle counter width must be positive");
      end
   endgenerate

   logic [DIV_W-1:0]  ph_q;
   logic [DIV_W-1:0]  split_idx;
   logic              wr_q;
   logic [BOOT_W-1:0] boot_q;
   logic              boot_last;

   always_comb begin
      split_idx = wr_q ? h1 : (h1 - DIV_W'(2));
      cyc_end   = (ph_q == (div - DIV_W'(1)));
      cyc_start = (ph_q == split_idx);
      boot_busy = (boot_q != '0);
      boot_last = (boot_q <= BOOT_W'(1));
      cyc_wr    = wr_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q    <= '0;
         wr_q    <= 1'b0;
         boot_q  <= BOOT_W'(BOOT_CYCLES);
         cyc_cnt <= '0;
      end else if (cyc_end) begin
         ph_q    <= '0;
         wr_q    <= boot_last & next_wr;
         cyc_cnt <= cyc_cnt + CYC_W'(1);
         if (boot_busy) begin
            boot_q <= boot_q - BOOT_W'(1);
         end
      end else begin
         ph_q <= ph_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/region_clk_phaser_timebase.sv
module region_clk_phaser_timebase
   import region_clk_phaser_pkg::*;
#(
   parameter int unsigned MASTER_W = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [MASTER_W-1:0] base_live,
   input  logic [PDIV_W-1:0]   pph_live,
   input  logic [PDIV_W-1:0]   pdiv,
   output logic [MASTER_W-1:0] master_cnt,
   output logic                ppu_dot
);

   logic [PDIV_W-1:0] pph_q;

   always_comb ppu_dot = (pph_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         master_cnt <= base_live;
         pph_q      <= pph_live;
      end else begin
         master_cnt <= master_cnt + MASTER_W'(1);
         pph_q      <= (pph_q == (pdiv - PDIV_W'(1))) ? '0 : (pph_q + PDIV_W'(1));
      end
   end

endmodule

// File: rtl/region_clk_phaser.sv
module region_clk_phaser
   import region_clk_phaser_pkg::*;
#(
   parameter int unsigned MASTER_W    = 32,
   parameter int unsigned CYC_W       = 16,
   parameter int unsigned COFF_W      = 5,
   parameter int unsigned POFF_W      = 3,
   parameter int unsigned BOOT_CYCLES = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [1:0]          region_sel,
   input  logic [COFF_W-1:0]   cpu_off,
   input  logic [POFF_W-1:0]   ppu_off,
   input  logic                warm_rst,
   input  logic [7:0]          sp_now,
   input  logic                next_wr,
   output logic                cyc_start,
   output logic                cyc_end,
   output logic                cyc_wr,
   output logic                boot_busy,
   output logic [CYC_W-1:0]    cyc_cnt,
   output logic [MASTER_W-1:0] master_cnt,
   output logic                ppu_dot,
   output logic [7:0]          sp_init,
   output logic                axy_clr
);

   phase_cfg_t          cfg_q;
   logic [MASTER_W-1:0] base_live;
   logic [PDIV_W-1:0]   pph_live;
   logic [DIV_W-1:0]    cfg_div;

   assign cfg_div = cfg_q.div;

   region_clk_phaser_cfg #(
      .COFF_W(COFF_W), .POFF_W(POFF_W), .MASTER_W(MASTER_W)
   ) u_cfg (
      .clk(clk), .rst(rst), .region_sel(region_sel), .cpu_off(cpu_off),
      .ppu_off(ppu_off), .warm_rst(warm_rst), .sp_now(sp_now),
      .cfg_q(cfg_q), .base_live(base_live), .pph_live(pph_live),
      .sp_init(sp_init), .axy_clr(axy_clr)
   );

   region_clk_phaser_cpu #(
      .CYC_W(CYC_W), .BOOT_CYCLES(BOOT_CYCLES)
   ) u_cpu (
      .clk(clk), .rst(rst), .div(cfg_q.div), .h1(cfg_q.h1), .next_wr(next_wr),
      .cyc_start(cyc_start), .cyc_end(cyc_end), .cyc_wr(cyc_wr),
      .boot_busy(boot_busy), .cyc_cnt(cyc_cnt)
   );

   region_clk_phaser_timebase #(
      .MASTER_W(MASTER_W)
   ) u_tb (
      .clk(clk), .rst(rst), .base_live(base_live), .pph_live(pph_live),
      .pdiv(cfg_q.pdiv), .master_cnt(master_cnt), .ppu_dot(ppu_dot)
   );

endmodule

// File: rtl/region_clk_phaser_chk.sv
module region_clk_phaser_chk
   import region_clk_phaser_pkg::*;
#(
   parameter int unsigned MASTER_W = 32,
   parameter int unsigned CYC_W    = 16
) (
   input logic                clk,
   input logic                rst,
   input logic                cyc_start,
   input logic                cyc_end,
   input logic                cyc_wr,
   input logic                boot_busy,
   input logic [CYC_W-1:0]    cyc_cnt,
   input logic [MASTER_W-1:0] master_cnt,
   input logic                ppu_dot,
   input logic [DIV_W-1:0]    div
);

   logic [1:0] starts_seen;

   always_ff @(posedge clk) begin
      if (rst || cyc_end) starts_seen <= 2'd0;
      else if (cyc_start) starts_seen <= starts_seen + 2'd1;
   end

   // R2
   one_start_per_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      cyc_end |-> ((starts_seen + {1'b0, cyc_start}) == 2'd1));

   // R5
   master_step_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (master_cnt == $past(master_cnt) + MASTER_W'(1)));

   // R8
   cycle_count_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(cyc_end)) |-> (cyc_cnt == $past(cyc_cnt) + CYC_W'(1)));

   // R7
   boot_reads_only_chk: assert property (@(posedge clk) disable iff (rst)
      cyc_wr |-> !boot_busy);

   // R4
   write_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(cyc_end)) |-> $stable(cyc_wr));

   // R6
   dot_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ppu_dot)) |-> !ppu_dot);

   // R10
   region_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> $stable(div));

endmodule

bind region_clk_phaser region_clk_phaser_chk #(
   .MASTER_W(MASTER_W), .CYC_W(CYC_W)
) u_chk (
   .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_end(cyc_end),
   .cyc_wr(cyc_wr), .boot_busy(boot_busy), .cyc_cnt(cyc_cnt),
   .master_cnt(master_cnt), .ppu_dot(ppu_dot), .div(cfg_div)
);

// File: tb/region_clk_phaser_tb.sv
`timescale 1ns/1ps
module region_clk_phaser_tb;

   localparam int NROW = 7;
   // sel, cpu_off, ppu_off, wr, div, h1, pdiv, cpu_off_eff, ppu_off_eff
   localparam int ROWS [NROW][9] = '{
      '{0,  0, 1, 0, 12, 6, 4,  0, 1},
      '{1,  3, 4, 1, 16, 8, 5,  3, 4},
      '{2,  2, 0, 1, 15, 7, 5,  2, 0},
      '{2, 14, 2, 0, 15, 7, 5, 14, 2},
      '{3,  5, 3, 1, 12, 6, 4,  5, 3},
      '{0, 20, 7, 1, 12, 6, 4, 11, 3},
      '{1, 15, 4, 0, 16, 8, 5, 15, 4}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  region_sel = 2'd0;
   logic [4:0]  cpu_off = 5'd0;
   logic [2:0]  ppu_off = 3'd1;
   logic        warm_rst = 1'b0;
   logic [7:0]  sp_now = 8'd0;
   logic        next_wr = 1'b0;
   logic        cyc_start, cyc_end, cyc_wr, boot_busy, ppu_dot, axy_clr;
   logic [15:0] cyc_cnt;
   logic [31:0] master_cnt;
   logic [7:0]  sp_init;

   int n_chk = 0;
   int n_fail = 0;
   int tnow = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   region_clk_phaser u_dut (
      .clk(clk), .rst(rst), .region_sel(region_sel), .cpu_off(cpu_off),
      .ppu_off(ppu_off), .warm_rst(warm_rst), .sp_now(sp_now), .next_wr(next_wr),
      .cyc_start(cyc_start), .cyc_end(cyc_end), .cyc_wr(cyc_wr),
      .boot_busy(boot_busy), .cyc_cnt(cyc_cnt), .master_cnt(master_cnt),
      .ppu_dot(ppu_dot), .sp_init(sp_init), .axy_clr(axy_clr)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s at t=%0d: actual=%0d expected=%0d", tag, tnow, act, exp);
      end
   endtask

   task automatic apply_reset(input int sel, input int coff, input int poff,
                              input bit warm, input logic [7:0] sp);
      @(negedge clk);
      rst = 1'b1; region_sel = 2'(sel); cpu_off = 5'(coff); ppu_off = 3'(poff);
      warm_rst = warm; sp_now = sp; next_wr = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      tnow = 0;
   endtask

   task automatic tick();
      @(negedge clk);
      tnow++;
   endtask

   task automatic run_to(input int t);
      while (tnow < t) tick();
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // Reset state, region 00, offsets 0/1: R5 R7 R8 R6 R2
      apply_reset(0, 0, 1, 1'b0, 8'h00);
      chk("R5 master preload", master_cnt, 12);
      chk("R8 cycle count reset", cyc_cnt, 0);
      chk("R7 boot busy at reset", boot_busy, 1);
      chk("R2 no start at reset", cyc_start, 0);
      chk("R2 no end at reset", cyc_end, 0);
      chk("R6 dot at reset", ppu_dot, 0);

      // Table walk: R1 R2 R3 R5 R6 R7 R8 R10
      for (int r = 0; r < NROW; r++) begin
         int div, h1, pdiv, base, poff;
         bit wr;
         div  = ROWS[r][4]; h1 = ROWS[r][5]; pdiv = ROWS[r][6];
         base = div + ROWS[r][7]; poff = ROWS[r][8]; wr = ROWS[r][3] != 0;
         apply_reset(ROWS[r][0], ROWS[r][1], ROWS[r][2], 1'b0, 8'h00);
         next_wr = wr;
         for (int t = 0; t < 10 * div; t++) begin
            int c, ph, sidx;
            bit iw;
            logic [3:0] exp_v, act_v;
            c  = t / div;
            ph = t % div;
            iw = wr && (c >= 8);
            sidx = iw ? h1 : h1 - 2;
            exp_v = {ph == sidx, ph == div - 1, iw, c < 8};
            act_v = {cyc_start, cyc_end, cyc_wr, boot_busy};
            chk($sformatf("R1/R2/R3/R7/R10 row %0d phase strobes", r), act_v, exp_v);
            chk($sformatf("R5/R8/R10 row %0d counts", r),
                {master_cnt, cyc_cnt}, {32'(base + t), 16'(c)});
            chk($sformatf("R6/R10 row %0d dot", r), ppu_dot, ((base + t - poff) % pdiv) == 0);
            if (t == 20) begin
               region_sel = 2'(ROWS[r][0] + 1);
               cpu_off    = 5'(ROWS[r][1] + 7);
               ppu_off    = 3'(ROWS[r][2] + 2);
            end
            tick();
         end
      end

      // R4: one-clock write request on the end strobe of cycle 9 (region 00)
      apply_reset(0, 0, 1, 1'b0, 8'h00);
      run_to(119);
      chk("R4 end strobe of cycle 9", cyc_end, 1);
      next_wr = 1'b1;
      tick();
      next_wr = 1'b0;
      chk("R4 write cycle begins", cyc_wr, 1);
      run_to(125);
      chk("R3 no start before write cut", cyc_start, 0);
      tick();
      chk("R3 start at write cut point", cyc_start, 1);
      run_to(133);
      chk("R4 request does not carry over", cyc_wr, 0);
      run_to(136);
      chk("R2 read cut point after write", cyc_start, 1);

      // R9: cold and warm reset values
      apply_reset(0, 0, 1, 1'b0, 8'h55);
      chk("R9 cold sp", sp_init, 8'hFD);
      chk("R9 cold clear", axy_clr, 1);
      apply_reset(0, 0, 1, 1'b1, 8'h40);
      chk("R9 warm sp", sp_init, 8'h3D);
      chk("R9 warm clear", axy_clr, 0);
      sp_now = 8'h10;
      tick();
      tick();
      chk("R9 warm sp held", sp_init, 8'h3D);
      apply_reset(2, 0, 0, 1'b1, 8'h01);
      chk("R9 warm sp wraps", sp_init, 8'hFE);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule